// File: doc/BRIEF.md
# Dual-Bank Power-of-Two Clock Divider

The block takes one input clock and drives two divided clock outputs, bank A and bank B. Each bank has its own 2-bit ratio select. Bank A offers divide by 1, 2, 4 or 8. Bank B offers divide by 2, 4, 8 or 16, so an input of 622.08 MHz gives 38.88 MHz at the largest bank B ratio. Both banks take their outputs from taps of one shared 4-bit counter that advances on the rising input edge. Every divided output therefore changes on the same input edge, and the divide-by-1 path is the input clock itself behind a clean gate.

An asynchronous master reset puts the counter at zero and drives both outputs low. Several copies of the block that leave reset together come up in the same phase. A run/stop enable and the two ratio selects are sampled on falling input edges. They are applied only while the counter sits at zero. At that point every tap is low and the input clock is low, so starting, stopping or changing a ratio never cuts or stretches a phase that has already begun.

Top module: `cdiv_dual_bank`

## Requirements
- R1: Bank A select 00 gives divide by 1, 01 gives divide by 2, 10 gives divide by 4 and 11 gives divide by 8. Every divided bank A output is high for exactly half its period, counted in input rising edges.
- R2: Bank B select 00 gives divide by 2, 01 gives divide by 4, 10 gives divide by 8 and 11 gives divide by 16. Each output is high for exactly half its period.
- R3: While the block runs, the bank A divide-by-1 output is high while the input clock is high and low while the input clock is low.
- R4: A divided output changes level only at an input rising edge. A bank A output and a bank B output with the same ratio are equal at every point in time.
- R5: While the master reset is asserted, both outputs are low, including the divide-by-1 path, and they go low as soon as the reset is asserted.
- R6: Suppose the enable is high and the master reset is released while the input clock is high. Then a divided output of ratio N first rises at the (N/2)-th input rising edge after release, and the divide-by-1 output is high at the first one.
- R7: The enable is sampled on falling input edges and takes effect only while the counter is zero. While the block is stopped, both outputs are low. When the enable returns, a divide-by-16 output first rises at the 8th rising edge after the enable is set. No high phase is shortened by a stop.
- R8: A new select value takes effect only while the counter is zero. Until then the old ratio continues, and no high phase of any length other than the old or the new half period appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| mrst_i | input | 1 | Asynchronous master reset, active high |
| en_i | input | 1 | Run enable, high to run |
| sel_a_i | input | 2 | Bank A ratio select (00 = /1 ... 11 = /8) |
| sel_b_i | input | 2 | Bank B ratio select (00 = /2 ... 11 = /16) |
| q_a_o | output | 1 | Bank A divided clock |
| q_b_o | output | 1 | Bank B divided clock |

## Verification
A counter that skips or repeats a count shows up at once as a divide-by-2 output that fails to toggle on a rising edge. At the larger ratios it shows up within one period as a high phase of the wrong length. A wrong phase register lets a stop or a ratio change land away from the zero count. That produces a short high pulse, visible within half a period of the change, or a stopped output that is not low. Because bank misalignment is symmetric, equal-ratio outputs of the two banks are compared sample by sample, so a skewed tap shows up within one input cycle.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // Width of each bank's ratio select
  localparam int unsigned SEL_W = 2;

  // Tap index into {counter, gated clock}: 0 is the gated input clock,
  // k selects counter bit k-1 (divide by 2**k).
  function automatic int unsigned tap_index(input int unsigned base,
                                            input int unsigned sel);
    return base + sel;
  endfunction

  // Division ratio implied by a tap index
  function automatic int unsigned tap_ratio(input int unsigned idx);
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/cdiv_chain.sv
module cdiv_chain #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             mrst_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge mrst_i) begin
    if (mrst_i)     cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign at_zero_o = (cnt_q == '0);

  // R7: while running, every rising edge advances the chain by one
  p_step_when_running_r7: assert property (@(posedge clk_i) disable iff (mrst_i)
    run_i |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R7: while stopped, the chain keeps its value
  p_hold_when_stopped_r7: assert property (@(posedge clk_i) disable iff (mrst_i)
    !run_i |=> $stable(cnt_q));

endmodule

// File: rtl/cdiv_phase_ctl.sv
module cdiv_phase_ctl
  import cdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             mrst_i,
  input  logic             at_zero_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  output logic             run_o,
  output logic [SEL_W-1:0] sel_a_o,
  output logic [SEL_W-1:0] sel_b_o
);

  // Boundary registers: loaded on a falling edge, and only while the chain
  // is at zero, when all taps and the input clock are low.
  logic             run_q;
  logic [SEL_W-1:0] sel_a_q, sel_b_q;
  logic             boundary;

  assign boundary = at_zero_i;

  always_ff @(negedge clk_i or posedge mrst_i) begin
    if (mrst_i) begin
      run_q   <= 1'b0;
      sel_a_q <= '0;
      sel_b_q <= '0;
    end else if (boundary) begin
      run_q   <= en_i;
      sel_a_q <= sel_a_i;
      sel_b_q <= sel_b_i;
    end
  end

  assign run_o   = run_q;
  assign sel_a_o = sel_a_q;
  assign sel_b_o = sel_b_q;

  // R7: enable is applied only at the zero count
  p_run_only_at_zero_r7: assert property (@(negedge clk_i) disable iff (mrst_i)
    !at_zero_i |=> $stable(run_q));

  // R8: ratio changes are applied only at the zero count
  p_sel_only_at_zero_r8: assert property (@(negedge clk_i) disable iff (mrst_i)
    !at_zero_i |=> ($stable(sel_a_q) && $stable(sel_b_q)));

endmodule

// File: rtl/cdiv_bank_tap.sv
module cdiv_bank_tap
  import cdiv_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned BASE  = 0
) (
  input  logic             clk_i,
  input  logic             mrst_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             q_o
);

  localparam int unsigned IDX_W = $clog2(CNT_W + 1);

  logic [CNT_W:0]   taps;
  logic [IDX_W-1:0] idx;

  generate
    if (BASE == 0) begin : g_with_bypass
      // Gate changes only while the clock is low (run_i moves on falling edges)
      assign taps = {cnt_i, clk_i & run_i};
    end else begin : g_divided_only
      assign taps = {cnt_i, 1'b0};
    end
  endgenerate

  assign idx = IDX_W'(tap_index(BASE, 32'(sel_i)));
  assign q_o = taps[idx];

  // R1, R2: a divide-by-2 selection toggles on every running rising edge
  p_half_toggle_r2: assert property (@(posedge clk_i) disable iff (mrst_i)
    (run_i && idx == IDX_W'(1)) |=> (idx != IDX_W'(1) || q_o != $past(q_o)));

endmodule

// File: rtl/cdiv_dual_bank.sv
module cdiv_dual_bank
  import cdiv_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned A_BASE = 0,
  parameter int unsigned B_BASE = 1
) (
  input  logic             clk_i,
  input  logic             mrst_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_a_i,
  input  logic [SEL_W-1:0] sel_b_i,
  output logic             q_a_o,
  output logic             q_b_o
);

  localparam int unsigned N_BANK = 2;

  logic [CNT_W-1:0] cnt;
  logic             at_zero;
  logic             run;
  logic [SEL_W-1:0] sel_act [N_BANK];
  logic             q_bank  [N_BANK];

  cdiv_chain #(.CNT_W(CNT_W)) u_chain (
    .clk_i     (clk_i),
    .mrst_i    (mrst_i),
    .run_i     (run),
    .cnt_o     (cnt),
    .at_zero_o (at_zero)
  );

  cdiv_phase_ctl u_phase (
    .clk_i     (clk_i),
    .mrst_i    (mrst_i),
    .at_zero_i (at_zero),
    .en_i      (en_i),
    .sel_a_i   (sel_a_i),
    .sel_b_i   (sel_b_i),
    .run_o     (run),
    .sel_a_o   (sel_act[0]),
    .sel_b_o   (sel_act[1])
  );

  generate
    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
      cdiv_bank_tap #(
        .CNT_W (CNT_W),
        .BASE  ((g == 0) ? A_BASE : B_BASE)
      ) u_tap (
        .clk_i  (clk_i),
        .mrst_i (mrst_i),
        .run_i  (run),
        .cnt_i  (cnt),
        .sel_i  (sel_act[g]),
        .q_o    (q_bank[g])
      );
    end
  endgenerate

  assign q_a_o = q_bank[0];
  assign q_b_o = q_bank[1];

  // R7: a stopped block drives both outputs low
  p_quiet_when_stopped_r7: assert property (@(negedge clk_i) disable iff (mrst_i)
    !run |-> (!q_a_o && !q_b_o));

endmodule

// File: tb/tb_cdiv_dual_bank.sv
module tb_cdiv_dual_bank;

  logic       clk = 1'b0;
  logic       mrst = 1'b1;
  logic       en = 1'b1;
  logic [1:0] sel_a = 2'd0;
  logic [1:0] sel_b = 2'd0;
  logic       q_a, q_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cdiv_dual_bank dut (
    .clk_i (clk), .mrst_i (mrst), .en_i (en),
    .sel_a_i (sel_a), .sel_b_i (sel_b),
    .q_a_o (q_a), .q_b_o (q_b)
  );

  // {select, bank A ratio, bank B ratio}
  localparam int VEC [4][3] = '{'{0, 1, 2}, '{1, 2, 4}, '{2, 4, 8}, '{3, 8, 16}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one sample point: 1 ns after a rising edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic pick(input bit bank_b);
    return bank_b ? q_b : q_a;
  endfunction

  // Measure period and high time (in rising edges) of a divided output
  task automatic measure(input bit bank_b, input int ratio, input string req);
    int per = 0, hi = 0, guard = 0;
    logic prev;
    prev = pick(bank_b);
    while (!(prev == 1'b0 && pick(bank_b) == 1'b1) && guard < 64) begin
      prev = pick(bank_b); step(); guard++;
    end
    do begin
      if (pick(bank_b)) hi++;
      prev = pick(bank_b); step(); per++;
    end while (!(prev == 1'b0 && pick(bank_b) == 1'b1) && per < 64);
    check(per == ratio, req, per, ratio);
    check(hi == ratio / 2, req, hi, ratio / 2);
  endtask

  // Watch bank B high phases; each complete one must be h1 or h2 edges long
  task automatic watch_b(input int cycles, input int h1, input int h2, input string req);
    int len = 0, seen = 0;
    bit started = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (q_b) len++;
      else begin
        if (started && len > 0) begin
          check(len == h1 || len == h2, req, len, h1);
          seen++;
        end
        started = 1'b1;
        len = 0;
      end
    end
    check(seen > 0, req, seen, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R5: reset state, including the divide-by-1 path while the clock is high
    repeat (3) step();
    check(q_a == 1'b0, "R5", q_a, 0);
    check(q_b == 1'b0, "R5", q_b, 0);

    // R6: release while clock high, sel A /1, sel B /16
    sel_b = 2'd3;
    @(posedge clk); #1 mrst = 1'b0;
    begin
      int first = 0;
      for (int e = 1; e <= 12; e++) begin
        step();
        if (e == 1) check(q_a == 1'b1, "R6", q_a, 1);
        if (q_b && first == 0) first = e;
      end
      check(first == 8, "R6", first, 8);
    end

    // R1/R2: vector table
    for (int v = 0; v < 4; v++) begin
      sel_a = VEC[v][0][1:0];
      sel_b = VEC[v][0][1:0];
      repeat (40) step();
      if (VEC[v][1] == 1) begin
        for (int k = 0; k < 4; k++) begin
          check(q_a == 1'b1, "R3", q_a, 1);   // clock high
          @(negedge clk); #1;
          check(q_a == 1'b0, "R3", q_a, 0);   // clock low
          step();
        end
      end else begin
        measure(1'b0, VEC[v][1], "R1");
      end
      measure(1'b1, VEC[v][2], "R2");
    end

    // R4: equal ratios on both banks, and changes only at rising edges
    sel_a = 2'd1; sel_b = 2'd0;
    repeat (40) step();
    for (int k = 0; k < 12; k++) begin
      logic post;
      post = q_b;
      check(q_a == q_b, "R4", q_a, q_b);
      @(negedge clk); #1;
      check(q_a == q_b, "R4", q_a, q_b);
      check(q_b == post, "R4", q_b, post);
      step();
    end
    sel_a = 2'd3; sel_b = 2'd2;
    repeat (40) step();
    for (int k = 0; k < 20; k++) begin
      check(q_a == q_b, "R4", q_a, q_b);
      step();
    end

    // R7: stop mid-period never shortens a /16 high phase
    sel_a = 2'd0; sel_b = 2'd3;
    repeat (40) step();
    fork
      watch_b(140, 8, 8, "R7");
      begin
        repeat (27) step();
        en = 1'b0;
        repeat (50) step();
        en = 1'b1;
      end
    join
    // R7: stopped outputs low, restart timing
    en = 1'b0;
    repeat (30) step();
    for (int k = 0; k < 6; k++) begin
      check(q_a == 1'b0 && q_b == 1'b0, "R7", {q_a, q_b}, 0);
      @(negedge clk); #1;
      check(q_a == 1'b0 && q_b == 1'b0, "R7", {q_a, q_b}, 0);
      step();
    end
    en = 1'b1;
    begin
      int first = 0;
      for (int e = 1; e <= 12; e++) begin
        step();
        if (q_b && first == 0) first = e;
      end
      check(first == 8, "R7", first, 8);
    end

    // R8: change /16 -> /2 just after a rising output edge; old ratio holds
    repeat (40) step();
    begin
      logic prev;
      prev = q_b;
      while (!(prev == 1'b0 && q_b == 1'b1)) begin prev = q_b; step(); end
    end
    sel_b = 2'd0;
    for (int k = 0; k < 7; k++) begin
      step();
      check(q_b == 1'b1, "R8", q_b, 1);
    end
    repeat (20) step();
    measure(1'b1, 2, "R8");
    fork
      watch_b(100, 8, 1, "R8");
      begin repeat (13) step(); sel_b = 2'd3; end
    join

    // R5: asynchronous assertion mid-run drives outputs low at once
    sel_a = 2'd0;
    repeat (20) step();
    mrst = 1'b1;
    #0.5;
    check(q_a == 1'b0, "R5", q_a, 0);
    check(q_b == 1'b0, "R5", q_b, 0);
    repeat (5) step();
    check(q_a == 1'b0 && q_b == 1'b0, "R5", {q_a, q_b}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule